// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects a parameterized set of level interrupt request lines and decides, every cycle, whether the most urgent request that is allowed to run may interrupt the code that is running now. Each line has a programmable priority, where a smaller number is more urgent, and an enable bit. A pending flag captures each request. When a line is accepted, the block issues a one-cycle strobe with the line number and a vector-table index. The index sits 16 slots above the line number, because the low slots are kept for system exceptions.

Accepted handlers can nest. The block keeps a small stack of the execution priorities that were preempted, plus an active flag for each line. A return strobe from the processor closes the innermost handler. Two masks gate acceptance. A threshold register, when nonzero, holds back every line whose priority number is equal to or above it. A global mask bit holds back everything. Configuration comes through a simple single-cycle write port. Context saving and vector fetch belong to the surrounding processor.

Top module: `prio_nest_intc`

## Requirements
- R1: Among lines that are pending, enabled, not active and not masked, the line with the numerically smallest priority is accepted.
- R2: When several such lines share the smallest priority, the lowest line number is accepted.
- R3: A line is accepted only if its priority number is strictly smaller than `exec_prio`. An equal priority never preempts.
- R4: Acceptance raises `take_valid` for one cycle, two clock edges after the request is first high. It comes with `take_irq` = line number and `take_vector` = line number + 16.
- R5: On acceptance, the line's pending flag clears and its active flag sets. `exec_prio` becomes the line's priority and `nest_depth` grows by one.
- R6: A `eoi` pulse while `nest_depth` is nonzero clears the innermost handler's active flag, restores the preempted `exec_prio` and lowers `nest_depth` by one. No acceptance happens in the same cycle. The thread level is encoded as `exec_prio` = 2^PRIO_W.
- R7: A line never preempts its own active handler, even after its priority is rewritten to a more urgent value. The new request stays pending and is accepted after that handler returns.
- R8: A nonzero threshold blocks every line whose priority number is at or above the threshold. A threshold of zero blocks nothing. Blocked requests stay pending.
- R9: While the global mask bit is set, no line is accepted. Requests stay pending and are taken once the mask clears.
- R10: A disabled line still latches its request as pending, but it is not accepted until it is enabled.
- R11: When `nest_depth` equals NEST_DEPTH, no further line is accepted.
- R12: After reset, all pending and active flags are zero, `nest_depth` is 0, `exec_prio` is the thread level, `take_valid` is 0, and every line has priority 0 and is disabled.
- R13: Write port kinds: `cfg_kind` 0 writes priority `cfg_wdata` to line `cfg_idx`. Kind 1 writes the enable bit from `cfg_wdata[0]`. Kind 2 writes the threshold. Kind 3 writes the global mask from `cfg_wdata[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | NUM_IRQ | Level request per line |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Register kind selector |
| cfg_idx | input | IDX_W | Target line for priority and enable writes |
| cfg_wdata | input | PRIO_W | Write data |
| eoi | input | 1 | Handler return strobe |
| take_valid | output | 1 | Acceptance strobe |
| take_irq | output | IDX_W | Accepted line number |
| take_vector | output | VEC_W | Vector-table index of accepted line |
| exec_prio | output | PRIO_W+1 | Current execution priority |
| nest_depth | output | CNT_W | Number of nested active handlers |
| pending | output | NUM_IRQ | Pending flags |
| active | output | NUM_IRQ | Active flags |

## Verification
The bench builds the block with eight lines, 3-bit priorities and a nesting depth of three. With eight lines, one byte-wide request pattern covers every line at once, so the table can state ties and mixed priorities compactly. With a depth of three, a short chain of ever more urgent requests fills the stack and reaches the full-stack refusal. It also keeps the threshold and self-preemption corners only a few cycles apart.

// File: rtl/pnic_pkg.sv
// Shared definitions for the nested priority interrupt controller.
// Assumes: write-port kind encoding is fixed by the requirements.
package pnic_pkg;
    typedef enum logic [1:0] {
        CFG_PRIO  = 2'd0,
        CFG_EN    = 2'd1,
        CFG_THR   = 2'd2,
        CFG_GMASK = 2'd3
    } cfg_kind_e;
endpackage

// File: rtl/pnic_regs.sv
// Configuration storage: per-line priority and enable, the threshold, and
// the global mask. Assumes a single write per cycle with an in-range index.
module pnic_regs
    import pnic_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 3,
    parameter int IDX_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  cfg_kind_e                 cfg_kind,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic [PRIO_W-1:0]         cfg_wdata,
    output logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic [NUM_IRQ-1:0]        enable,
    output logic [PRIO_W-1:0]         thr,
    output logic                      gmask
);

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        logic hit;
        assign hit = cfg_we && (cfg_idx == IDX_W'(g));

        // Priority field of one line
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_flat[g*PRIO_W +: PRIO_W] <= '0;
            else if (hit && cfg_kind == CFG_PRIO)
                prio_flat[g*PRIO_W +: PRIO_W] <= cfg_wdata;
        end

        // Enable bit of one line
        always_ff @(posedge clk) begin
            if (!rst_n)
                enable[g] <= 1'b0;
            else if (hit && cfg_kind == CFG_EN)
                enable[g] <= cfg_wdata[0];
        end
    end

    // Threshold and global mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr   <= '0;
            gmask <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_kind == CFG_THR)   thr   <= cfg_wdata;
            if (cfg_kind == CFG_GMASK) gmask <= cfg_wdata[0];
        end
    end

endmodule

// File: rtl/pnic_arbiter.sv
// Combinational selection of the most urgent candidate line.
// Assumes smaller priority number is more urgent; ties go to the lower index.
module pnic_arbiter #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 3,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_IRQ-1:0]        cand,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic                      found,
    output logic [IDX_W-1:0]          win_idx,
    output logic [PRIO_W-1:0]         win_prio
);

    // Linear scan; strict compare keeps the earliest index on a tie
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] < win_prio)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/pnic_stack.sv
// LIFO of preempted context words (execution priority and line number).
// Assumes the caller never pushes when full nor pops when empty.
module pnic_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     push_data,
    output logic [W-1:0]     top_data,
    output logic [CNT_W-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] top_ptr;

    assign top_ptr  = count - CNT_W'(1);
    assign top_data = (count != '0) ? mem[top_ptr[PTR_W-1:0]] : '0;

    // Storage and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[count[PTR_W-1:0]] <= push_data;
            count <= count + CNT_W'(1);
        end else if (pop) begin
            count <= count - CNT_W'(1);
        end
    end

endmodule

// File: rtl/prio_nest_intc.sv
// Nested priority interrupt controller top. Samples level requests into
// pending flags, selects the most urgent eligible line, preempts only on a
// strictly more urgent priority, and tracks nesting until each return.
// Assumes eoi is issued by the handler that was accepted last.
module prio_nest_intc
    import pnic_pkg::*;
#(
    parameter int NUM_IRQ    = 32,
    parameter int PRIO_W     = 3,
    parameter int NEST_DEPTH = 4,
    parameter int SYS_SLOTS  = 16,
    localparam int IDX_W     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    localparam int VEC_W     = $clog2(NUM_IRQ + SYS_SLOTS),
    localparam int CNT_W     = $clog2(NEST_DEPTH + 1),
    localparam int EP_W      = PRIO_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_kind,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [PRIO_W-1:0]  cfg_wdata,
    input  logic               eoi,
    output logic               take_valid,
    output logic [IDX_W-1:0]   take_irq,
    output logic [VEC_W-1:0]   take_vector,
    output logic [EP_W-1:0]    exec_prio,
    output logic [CNT_W-1:0]   nest_depth,
    output logic [NUM_IRQ-1:0] pending,
    output logic [NUM_IRQ-1:0] active
);
    localparam logic [EP_W-1:0] THREAD_LVL = EP_W'(1) << PRIO_W;
    localparam int              CTX_W      = EP_W + IDX_W;

    logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
    logic [NUM_IRQ-1:0]        enable;
    logic [PRIO_W-1:0]         thr;
    logic                      gmask_w;

    logic [NUM_IRQ-1:0] pend_q, act_q, cand, acc_onehot;
    logic [EP_W-1:0]    cur_prio;
    logic [IDX_W-1:0]   cur_irq;
    logic               found, accept, eoi_eff, stack_full;
    logic [IDX_W-1:0]   win_idx;
    logic [PRIO_W-1:0]  win_prio;
    logic [CTX_W-1:0]   ctx_top;
    logic [CNT_W-1:0]   depth;

    pnic_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_kind_e'(cfg_kind)),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .prio_flat (prio_flat),
        .enable    (enable),
        .thr       (thr),
        .gmask     (gmask_w)
    );

    // Per-line eligibility: pending, enabled, not running, under threshold
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_elig
        logic thr_ok;
        assign thr_ok  = (thr == '0) || (prio_flat[g*PRIO_W +: PRIO_W] < thr);
        assign cand[g] = pend_q[g] & enable[g] & ~act_q[g] & thr_ok;
    end

    pnic_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
        .cand      (cand),
        .prio_flat (prio_flat),
        .found     (found),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    assign eoi_eff    = eoi && (depth != '0);
    assign stack_full = (depth == CNT_W'(NEST_DEPTH));
    assign accept     = found && ({1'b0, win_prio} < cur_prio) && !gmask_w
                        && !eoi_eff && !stack_full;
    assign acc_onehot = accept ? (NUM_IRQ'(1) << win_idx) : '0;

    pnic_stack #(.DEPTH(NEST_DEPTH), .W(CTX_W), .CNT_W(CNT_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept),
        .pop       (eoi_eff),
        .push_data ({cur_prio, cur_irq}),
        .top_data  (ctx_top),
        .count     (depth)
    );

    // Pending capture: requests set, acceptance clears
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q | irq_req) & ~acc_onehot;
    end

    // Active flags and current running context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q    <= '0;
            cur_prio <= THREAD_LVL;
            cur_irq  <= '0;
        end else if (accept) begin
            act_q    <= act_q | acc_onehot;
            cur_prio <= {1'b0, win_prio};
            cur_irq  <= win_idx;
        end else if (eoi_eff) begin
            act_q    <= act_q & ~(NUM_IRQ'(1) << cur_irq);
            cur_prio <= ctx_top[CTX_W-1 -: EP_W];
            cur_irq  <= ctx_top[IDX_W-1:0];
        end
    end

    // Acceptance strobe and vector index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_valid  <= 1'b0;
            take_irq    <= '0;
            take_vector <= '0;
        end else begin
            take_valid  <= accept;
            take_irq    <= win_idx;
            take_vector <= VEC_W'(win_idx) + VEC_W'(SYS_SLOTS);
        end
    end

    assign exec_prio  = cur_prio;
    assign nest_depth = depth;
    assign pending    = pend_q;
    assign active     = act_q;

endmodule

// File: rtl/pnic_checker.sv
// Temporal checks for the nested priority interrupt controller, bound to
// every instance of the top. Assumes synchronous active-low reset.
module pnic_checker #(
    parameter int NUM_IRQ    = 32,
    parameter int PRIO_W     = 3,
    parameter int NEST_DEPTH = 4,
    parameter int SYS_SLOTS  = 16,
    parameter int IDX_W      = 5,
    parameter int VEC_W      = 6,
    parameter int CNT_W      = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               eoi,
    input logic               take_valid,
    input logic [IDX_W-1:0]   take_irq,
    input logic [VEC_W-1:0]   take_vector,
    input logic [PRIO_W:0]    exec_prio,
    input logic [CNT_W-1:0]   nest_depth,
    input logic [NUM_IRQ-1:0] active,
    input logic               gmask
);
    logic [NUM_IRQ-1:0] active_d;
    logic               gmask_d;

    // Previous-cycle copies of active flags and global mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_d <= '0;
            gmask_d  <= 1'b0;
        end else begin
            active_d <= active;
            gmask_d  <= gmask;
        end
    end

    assert_strict_preempt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> exec_prio < $past(exec_prio));

    assert_vector_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> take_vector == VEC_W'(take_irq) + VEC_W'(SYS_SLOTS));

    assert_taken_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> active[take_irq]);

    assert_depth_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(active) == int'(nest_depth));

    assert_return_pops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && nest_depth != '0) |=> nest_depth == $past(nest_depth) - CNT_W'(1));

    assert_no_self_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> !active_d[take_irq]);

    assert_gmask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> !gmask_d);

    assert_depth_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        int'(nest_depth) <= NEST_DEPTH);

endmodule

bind prio_nest_intc pnic_checker #(
    .NUM_IRQ    (NUM_IRQ),
    .PRIO_W     (PRIO_W),
    .NEST_DEPTH (NEST_DEPTH),
    .SYS_SLOTS  (SYS_SLOTS),
    .IDX_W      (IDX_W),
    .VEC_W      (VEC_W),
    .CNT_W      (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eoi         (eoi),
    .take_valid  (take_valid),
    .take_irq    (take_irq),
    .take_vector (take_vector),
    .exec_prio   (exec_prio),
    .nest_depth  (nest_depth),
    .active      (active),
    .gmask       (gmask_w)
);

// File: tb/prio_nest_intc_tb.sv
// Self-checking bench: table-driven arbitration, then directed corner cases.
module prio_nest_intc_tb;
    localparam int NI = 8;
    localparam int PW = 3;
    localparam int ND = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] irq_req = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_kind = '0;
    logic [2:0]    cfg_idx = '0;
    logic [PW-1:0] cfg_wdata = '0;
    logic          eoi = 1'b0;
    logic          take_valid;
    logic [2:0]    take_irq;
    logic [4:0]    take_vector;
    logic [PW:0]   exec_prio;
    logic [1:0]    nest_depth;
    logic [NI-1:0] pending, active;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    prio_nest_intc #(.NUM_IRQ(NI), .PRIO_W(PW), .NEST_DEPTH(ND)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cfg_we(cfg_we),
        .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .eoi(eoi), .take_valid(take_valid), .take_irq(take_irq),
        .take_vector(take_vector), .exec_prio(exec_prio),
        .nest_depth(nest_depth), .pending(pending), .active(active)
    );

    // Line priorities used throughout: line i gets LP[i]
    localparam logic [PW-1:0] LP [NI] = '{3'd5, 3'd3, 3'd3, 3'd6, 3'd1, 3'd7, 3'd2, 3'd4};

    // Vector: {expect_valid, expect_line[2:0], request_pattern[7:0]}
    localparam logic [11:0] VEC [8] = '{12'h801, 12'h906, 12'hCFF, 12'hFA0,
                                         12'hE68, 12'h809, 12'h000, 12'hF88};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic cfg(input logic [1:0] k, input int idx, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = k; cfg_idx = 3'(idx); cfg_wdata = PW'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Request for one cycle; returns at the negedge after the accept edge
    task automatic pulse(input logic [NI-1:0] m);
        @(negedge clk);
        irq_req = m;
        @(negedge clk);
        irq_req = '0;
        @(negedge clk);
    endtask

    task automatic do_eoi();
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            eoi = (nest_depth != 0);
        end
        @(negedge clk);
        eoi = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_take(input string req, input int line);
        check(take_valid == 1'b1, req, int'(take_valid), 1);
        check(int'(take_irq) == line, req, int'(take_irq), line);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(exec_prio == 4'd8, "R12", int'(exec_prio), 8);
        check(nest_depth == 0 && pending == 0 && active == 0 && !take_valid,
              "R12", int'(nest_depth), 0);
        // R12/R10: lines disabled after reset, request latches but is not taken
        pulse(8'h01);
        check(!take_valid && pending[0], "R12", int'(take_valid), 0);

        // R13 program priorities and enables
        for (int i = 0; i < NI; i++) begin
            cfg(2'd0, i, int'(LP[i]));
            cfg(2'd1, i, 1);
        end
        @(negedge clk);
        // pending[0] from earlier is now accepted once enabled
        drain();

        // R1/R2/R4 table-driven arbitration
        for (int v = 0; v < 8; v++) begin
            pulse(VEC[v][7:0]);
            check(take_valid == VEC[v][11], "R1", int'(take_valid), int'(VEC[v][11]));
            if (VEC[v][11]) begin
                check(int'(take_irq) == int'(VEC[v][10:8]), "R2", int'(take_irq), int'(VEC[v][10:8]));
                check(int'(take_vector) == int'(VEC[v][10:8]) + 16, "R4",
                      int'(take_vector), int'(VEC[v][10:8]) + 16);
            end
            drain();
        end

        // R3/R5/R6 nesting and equal-priority refusal
        pulse(8'h02);
        expect_take("R5", 1);
        check(exec_prio == 4'd3, "R5", int'(exec_prio), 3);
        pulse(8'h04);
        check(!take_valid && pending[2], "R3", int'(take_valid), 0);
        pulse(8'h10);
        expect_take("R3", 4);
        check(exec_prio == 4'd1 && nest_depth == 2 && active == 8'h12, "R5", int'(active), 'h12);
        check(!pending[4], "R5", int'(pending[4]), 0);
        do_eoi();
        check(exec_prio == 4'd3 && nest_depth == 1 && active == 8'h02, "R6", int'(exec_prio), 3);
        @(negedge clk);
        check(!take_valid, "R3", int'(take_valid), 0);
        do_eoi();
        check(exec_prio == 4'd8 && nest_depth == 0, "R6", int'(exec_prio), 8);
        @(negedge clk);
        expect_take("R6", 2);
        drain();

        // R7 no self-preemption after priority raise
        pulse(8'h01);
        expect_take("R7", 0);
        cfg(2'd0, 0, 0);
        pulse(8'h01);
        check(!take_valid && pending[0] && active[0], "R7", int'(take_valid), 0);
        do_eoi();
        @(negedge clk);
        expect_take("R7", 0);
        check(exec_prio == 4'd0, "R7", int'(exec_prio), 0);
        drain();
        cfg(2'd0, 0, 5);

        // R8 threshold: equal priority blocked, more urgent passes
        cfg(2'd2, 0, 4);
        pulse(8'h80);
        check(!take_valid && pending[7], "R8", int'(take_valid), 0);
        pulse(8'h40);
        expect_take("R8", 6);
        drain();
        check(pending[7] && nest_depth == 0, "R8", int'(pending[7]), 1);
        cfg(2'd2, 0, 0);
        @(negedge clk);
        expect_take("R8", 7);
        drain();

        // R9 global mask
        cfg(2'd3, 0, 1);
        pulse(8'h10);
        check(!take_valid && pending[4], "R9", int'(take_valid), 0);
        cfg(2'd3, 0, 0);
        @(negedge clk);
        expect_take("R9", 4);
        drain();

        // R10 disabled line stays pending
        cfg(2'd1, 5, 0);
        pulse(8'h20);
        check(!take_valid && pending[5], "R10", int'(take_valid), 0);
        cfg(2'd1, 5, 1);
        @(negedge clk);
        expect_take("R10", 5);
        drain();

        // R11 full nesting stack refuses further acceptance
        pulse(8'h01);
        expect_take("R11", 0);
        pulse(8'h80);
        expect_take("R11", 7);
        pulse(8'h40);
        expect_take("R11", 6);
        check(nest_depth == 3, "R11", int'(nest_depth), 3);
        pulse(8'h10);
        check(!take_valid && pending[4], "R11", int'(take_valid), 0);
        do_eoi();
        check(nest_depth == 2 && exec_prio == 4'd4, "R11", int'(exec_prio), 4);
        @(negedge clk);
        expect_take("R11", 4);
        drain();
        check(nest_depth == 0 && active == 0 && exec_prio == 4'd8, "R6", int'(exec_prio), 8);

        summary();
    end

endmodule